// File: doc/BRIEF.md
# GPIO Edge Capture and Interrupt Combiner

This block watches a bus of already-synchronous general-purpose pins and keeps one sticky status bit per pin. The bits are grouped in 32-bit banks. A bit is set when its pin makes a transition that software has armed: a low-to-high step, a high-to-low step, or both. The pin must also be configured as an input. Software acknowledges captured transitions by strobing a bank index together with a mask, and every 1 in that mask clears the matching bit.

The captured status is condensed into three registered, level-sensitive interrupt lines. Pin 0 and pin 1 each get a line of their own. Every other pin shares the third line. The block also watches a fixed, per-bank set of wake-capable pins. While the core reports that it is halted, any level change on one of those pins, if it is an input, produces a one-cycle wake pulse. Pins whose index is at or beyond the `LINES` parameter do not exist, and nothing they do has any effect.

Top module: `gpio_edge_irq_top`

## Requirements
- R1: A status bit is set on the clock edge at which its pin is sampled 1 after having been sampled 0 on the previous edge, provided that pin's rising enable is 1 and its direction bit is 0 (0 = input, 1 = output).
- R2: A status bit is set when its pin is sampled 0 after having been sampled 1 on the previous edge, provided that pin's falling enable is 1 and its direction bit is 0.
- R3: Status bits stay set until cleared. When `clr_valid` is 1, each 1 in `clr_mask` clears the matching bit of bank `clr_bank`, where bank b holds pins 32*b to 32*b+31 and mask bit i maps to pin 32*b+i. Bits whose mask bit is 0, and bits of other banks, are unchanged.
- R4: If a qualifying edge and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: `irq_pin0` and `irq_pin1` equal the status bits of pin 0 and pin 1, delayed by one register stage.
- R6: `irq_rest` is the OR of the status bits of pins 2 and up, delayed by one register stage.
- R7: `wake_req` is a single-cycle pulse, asserted one edge after an input-direction, wake-capable pin is sampled at a level different from its previous sample while `halted` is 1. The wake-capable masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R8: There is no wake pulse when `halted` is 0, when the changing pin is an output, or when the pin is not wake-capable.
- R9: Pins with an index at or above `LINES` (default 100) never set a status bit and never cause a wake pulse.
- R10: The previous-level sample is taken for every pin, outputs included. A pin that changes while it is an output, and is then switched to input, records no edge.
- R11: After reset, all status bits, the interrupt lines and `wake_req` are 0, and the previous samples are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 32*NUM_BANKS | Pin levels, already synchronous |
| dir_out | input | 32*NUM_BANKS | Per-pin direction, 1 = output |
| rise_en | input | 32*NUM_BANKS | Per-pin rising-transition capture enable |
| fall_en | input | 32*NUM_BANKS | Per-pin falling-transition capture enable |
| clr_valid | input | 1 | Clear strobe |
| clr_bank | input | BANK_IDX_W | Bank addressed by the clear strobe |
| clr_mask | input | 32 | Write-one-to-clear mask |
| halted | input | 1 | Core is halted |
| status_flat | output | 32*NUM_BANKS | Sticky captured-transition bits |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_rest | output | 1 | Combined interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
The embedded assertions check several properties on every cycle. A bit survives until it is cleared, and an edge beats a simultaneous clear. A new status bit never appears without a level change on an input pin, and pins beyond `LINES` stay zero. Each interrupt line tracks the status of the cycle before, and a wake pulse is always preceded by a halted, wake-capable change. The per-bank wake mask values, the false-edge case after a direction switch, and the absence of a wake for non-wake pins can only be shown by the bench. It drives directed scenarios and a long pseudo-random run against a behavioural per-pin model, compared on every clock.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   localparam int BANK_W    = 32;
   localparam int MAX_BANKS = 4;

   typedef logic [BANK_W-1:0] bank_word_t;

   // Hard-wired wake-capable pin set, one word per bank.
   function automatic bank_word_t wake_mask(input int idx);
      case (idx)
         0:       return 32'h8003_FE1B;
         1:       return 32'h0020_01FC;
         2:       return 32'hEC08_0000;
         3:       return 32'h0012_007F;
         default: return '0;
      endcase
   endfunction

   // Bits of bank idx whose global pin index lies below the line count.
   function automatic bank_word_t line_mask(input int idx, input int lines);
      bank_word_t m;
      for (int i = 0; i < BANK_W; i++)
         m[i] = ((idx * BANK_W + i) < lines);
      return m;
   endfunction
endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_edge_pkg::*;
#(
   parameter int BANK_IDX = 0,
   parameter int LINES    = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  bank_word_t pin,
   input  bank_word_t dir,
   input  bank_word_t ren,
   input  bank_word_t fen,
   input  logic       clr_hit,
   input  bank_word_t clr_mask,
   output bank_word_t status,
   output logic       wake_hit
);
   localparam bank_word_t VALID = line_mask(BANK_IDX, LINES);
   localparam bank_word_t WAKE  = wake_mask(BANK_IDX) & VALID;

   bank_word_t prev_q, stat_q;
   bank_word_t is_in, rise, fall, edges, clr_eff, stat_d;

   always_comb begin
      is_in   = ~dir & VALID;
      rise    = pin & ~prev_q & ren & is_in;
      fall    = ~pin & prev_q & fen & is_in;
      edges   = rise | fall;
      clr_eff = clr_hit ? clr_mask : '0;
      // new edges are OR-ed after the clear, so they win a collision
      stat_d  = (stat_q & ~clr_eff) | edges;
      wake_hit = |((pin ^ prev_q) & is_in & WAKE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= pin;   // every pin, output or not
         stat_q <= stat_d;
      end
   end

   assign status = stat_q;

   // R3: a set bit that was not cleared is still set
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> (($past(stat_q) & ~$past(clr_eff) & ~stat_q) == '0));
   // R4: an edge always leaves its bit set, clear or not
   p_edge_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> (($past(edges) & ~stat_q) == '0));
   // R1/R2/R10: a newly set bit needs an input pin whose sample changed
   p_new_needs_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> ((stat_q & ~$past(stat_q) & ~($past(pin) ^ $past(prev_q))) == '0));
   p_new_input_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> ((stat_q & ~$past(stat_q) & $past(dir)) == '0));
   // R9: absent pins stay clear
   p_absent_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & ~VALID) == '0);
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
   import gpio_edge_pkg::*;
#(
   parameter int NUM_BANKS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0]   status,
   output logic                          irq0,
   output logic                          irq1,
   output logic                          irq_rest
);
   localparam int PINS = NUM_BANKS * BANK_W;

   logic rest_any;
   assign rest_any = |status[PINS-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq0     <= 1'b0;
         irq1     <= 1'b0;
         irq_rest <= 1'b0;
      end else begin
         irq0     <= status[0];
         irq1     <= status[1];
         irq_rest <= rest_any;
      end
   end

   p_irq0_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> (irq0 == $past(status[0])) && (irq1 == $past(status[1])));
   p_rest_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1 |=> (irq_rest == ($past(status[PINS-1:2]) != '0)));
endmodule

// File: rtl/gpio_wake_pulse.sv
module gpio_wake_pulse #(
   parameter int NUM_BANKS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] hit,
   input  logic                 halted,
   output logic                 wake_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_req <= 1'b0;
      else        wake_req <= halted && (|hit);
   end

   p_wake_needs_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(halted));
   p_wake_needs_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> ($past(hit) != '0));
endmodule

// File: rtl/gpio_edge_irq_top.sv
module gpio_edge_irq_top
   import gpio_edge_pkg::*;
#(
   parameter int NUM_BANKS  = 4,
   parameter int LINES      = 100,
   parameter int PINS       = NUM_BANKS * BANK_W,
   parameter int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PINS-1:0]       pin_in,
   input  logic [PINS-1:0]       dir_out,
   input  logic [PINS-1:0]       rise_en,
   input  logic [PINS-1:0]       fall_en,
   input  logic                  clr_valid,
   input  logic [BANK_IDX_W-1:0] clr_bank,
   input  logic [BANK_W-1:0]     clr_mask,
   input  logic                  halted,
   output logic [PINS-1:0]       status_flat,
   output logic                  irq_pin0,
   output logic                  irq_pin1,
   output logic                  irq_rest,
   output logic                  wake_req
);
   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must lie in 1..%0d", MAX_BANKS);
   end
   if (LINES < 3 || LINES > PINS) begin : g_bad_lines
      $error("LINES must lie in 3..PINS");
   end
   if (PINS != NUM_BANKS * BANK_W) begin : g_bad_pins
      $error("PINS is derived and must not be overridden");
   end

   logic [NUM_BANKS-1:0] wake_hits;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit_this;
      assign hit_this = clr_valid && (clr_bank == BANK_IDX_W'(b));
      gpio_edge_bank #(.BANK_IDX(b), .LINES(LINES)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (pin_in [b*BANK_W +: BANK_W]),
         .dir      (dir_out[b*BANK_W +: BANK_W]),
         .ren      (rise_en[b*BANK_W +: BANK_W]),
         .fen      (fall_en[b*BANK_W +: BANK_W]),
         .clr_hit  (hit_this),
         .clr_mask (clr_mask),
         .status   (status_flat[b*BANK_W +: BANK_W]),
         .wake_hit (wake_hits[b])
      );
   end

   gpio_irq_merge #(.NUM_BANKS(NUM_BANKS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .status   (status_flat),
      .irq0     (irq_pin0),
      .irq1     (irq_pin1),
      .irq_rest (irq_rest)
   );

   gpio_wake_pulse #(.NUM_BANKS(NUM_BANKS)) u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (wake_hits),
      .halted   (halted),
      .wake_req (wake_req)
   );
endmodule

// File: tb/test_gpio_edge_irq_top.sv
`timescale 1ns/1ps
module test_gpio_edge_irq_top;
   localparam int NB = 4;
   localparam int NP = 128;
   localparam int NL = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0] pin_in = '0, dir_out = '0, rise_en = '0, fall_en = '0;
   logic clr_valid = 1'b0;
   logic [1:0] clr_bank = '0;
   logic [31:0] clr_mask = '0;
   logic halted = 1'b0;
   logic [NP-1:0] status_flat;
   logic irq_pin0, irq_pin1, irq_rest, wake_req;

   always #5 clk = ~clk;

   gpio_edge_irq_top #(.NUM_BANKS(NB), .LINES(NL)) i_gpio_edge_irq_top (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir_out(dir_out),
      .rise_en(rise_en), .fall_en(fall_en), .clr_valid(clr_valid),
      .clr_bank(clr_bank), .clr_mask(clr_mask), .halted(halted),
      .status_flat(status_flat), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
      .irq_rest(irq_rest), .wake_req(wake_req));

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   // behavioural reference state
   bit m_prev [NP];
   bit m_stat [NP];
   bit m_i0, m_i1, m_ix, m_wake;
   logic [31:0] wmask [NB] = '{32'h8003FE1B, 32'h002001FC, 32'hEC080000, 32'h0012007F};

   task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [NP-1:0] model_vec();
      logic [NP-1:0] v;
      for (int i = 0; i < NP; i++) v[i] = m_stat[i];
      return v;
   endfunction

   task automatic model_step();
      bit any_rest = 0;
      bit wk = 0;
      for (int i = 2; i < NP; i++) any_rest |= m_stat[i];
      m_i0 = m_stat[0];
      m_i1 = m_stat[1];
      m_ix = any_rest;
      for (int i = 0; i < NP; i++) begin
         bit valid_in = (i < NL) && !dir_out[i];
         bit edge_seen = valid_in &&
            ((pin_in[i] && !m_prev[i] && rise_en[i]) || (!pin_in[i] && m_prev[i] && fall_en[i]));
         bit clr = clr_valid && (int'(clr_bank) == i / 32) && clr_mask[i % 32];
         if (halted && valid_in && wmask[i / 32][i % 32] && (pin_in[i] != m_prev[i])) wk = 1;
         m_stat[i] = (m_stat[i] && !clr) || edge_seen;
         m_prev[i] = pin_in[i];
      end
      m_wake = wk;
   endtask

   // one clock: model follows the edge, outputs compared 1 ns later
   task automatic cyc();
      @(posedge clk);
      model_step();
      #1;
      check("R1 R2 R3 R4 R9 R10 status", status_flat, model_vec());
      check("R5 irq_pin0", NP'(irq_pin0), NP'(m_i0));
      check("R5 irq_pin1", NP'(irq_pin1), NP'(m_i1));
      check("R6 irq_rest", NP'(irq_rest), NP'(m_ix));
      check("R7 R8 wake_req", NP'(wake_req), NP'(m_wake));
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      lf = 32'hACE1_2345;
      for (int i = 0; i < NP; i++) begin m_prev[i] = 0; m_stat[i] = 0; end
      m_i0 = 0; m_i1 = 0; m_ix = 0; m_wake = 0;
      repeat (3) @(posedge clk);
      #1;
      // R11: reset state
      check("R11 status", status_flat, '0);
      check("R11 irqs/wake", NP'({irq_pin0, irq_pin1, irq_rest, wake_req}), '0);
      rst_n = 1'b1;
      rise_en[31:0] = 32'h0000_0021;
      cyc();

      // R1 rising on pin 0, then R5 one stage later
      pin_in[0] = 1; cyc();
      check("R1 pin0 captured", NP'(status_flat[0]), NP'(1));
      check("R5 irq_pin0 not yet", NP'(irq_pin0), NP'(0));
      cyc();
      check("R5 irq_pin0 raised", NP'(irq_pin0), NP'(1));

      // R2: falling needs its own enable
      pin_in[1] = 1; cyc(); pin_in[1] = 0; cyc();
      check("R2 pin1 unarmed", NP'(status_flat[1]), NP'(0));
      fall_en[1] = 1; pin_in[1] = 1; cyc(); pin_in[1] = 0; cyc();
      check("R2 pin1 falling", NP'(status_flat[1]), NP'(1));

      // R3: clear bit 0 only
      clr_valid = 1; clr_bank = 0; clr_mask = 32'h1; cyc(); clr_valid = 0;
      check("R3 write-one clear", NP'(status_flat[1:0]), NP'(2'b10));

      // R4: edge and clear together
      pin_in[5] = 1; cyc(); pin_in[5] = 0; cyc();
      pin_in[5] = 1; clr_valid = 1; clr_mask = 32'h20; cyc(); clr_valid = 0;
      check("R4 edge beats clear", NP'(status_flat[5]), NP'(1));
      pin_in[5] = 0; clr_valid = 1; cyc(); clr_valid = 0;
      check("R3 plain clear", NP'(status_flat[5]), NP'(0));
      cyc();

      // R6: bank 2 pin feeds combined line
      rise_en[67] = 1; pin_in[67] = 1; cyc(); cyc();
      check("R6 irq_rest raised", NP'(irq_rest), NP'(1));
      clr_valid = 1; clr_bank = 2; clr_mask = 32'h8; cyc(); clr_valid = 0; cyc();
      check("R6 irq_rest dropped", NP'(irq_rest), NP'(0));

      // R7 / R8: wake behaviour
      halted = 1; pin_in[0] = 0; cyc();
      check("R7 wake pulse", NP'(wake_req), NP'(1));
      cyc();
      check("R7 pulse one cycle", NP'(wake_req), NP'(0));
      pin_in[2] = 1; cyc();
      check("R8 non-wake pin", NP'(wake_req), NP'(0));
      halted = 0; pin_in[0] = 1; cyc();
      check("R8 not halted", NP'(wake_req), NP'(0));
      halted = 1; dir_out[0] = 1; pin_in[0] = 0; cyc();
      check("R8 output pin", NP'(wake_req), NP'(0));
      dir_out[0] = 0; cyc();
      pin_in[96] = 1; cyc();
      check("R7 bank3 wake pin", NP'(wake_req), NP'(1));

      // R9: pin 116 is wake-capable by mask but absent
      rise_en[116] = 1; fall_en[116] = 1; pin_in[116] = 1; cyc();
      check("R9 absent no wake", NP'(wake_req), NP'(0));
      check("R9 absent no status", NP'(status_flat[116]), NP'(0));
      halted = 0;

      // R10: toggling while output leaves no edge behind
      rise_en[7] = 1; fall_en[7] = 1; dir_out[7] = 1;
      pin_in[7] = 1; cyc(); pin_in[7] = 0; cyc(); pin_in[7] = 1; cyc();
      dir_out[7] = 0; cyc();
      check("R10 no false edge", NP'(status_flat[7]), NP'(0));
      pin_in[7] = 0; cyc();
      check("R10 real edge after switch", NP'(status_flat[7]), NP'(1));

      // pseudo-random soak against the model
      for (int k = 0; k < 3000; k++) begin
         for (int w = 0; w < 4; w++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            pin_in[w*32 +: 32] = pin_in[w*32 +: 32] ^ (lf & {lf[7:0], lf[31:8]});
            if (lf[3:0] == 0) dir_out[w*32 +: 32] = lf ^ 32'h5A5A_0F0F;
            if (lf[5:2] == 1) rise_en[w*32 +: 32] = ~lf;
            if (lf[6:3] == 2) fall_en[w*32 +: 32] = {lf[15:0], lf[31:16]};
         end
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         clr_valid = lf[0] & lf[1];
         clr_bank = lf[3:2];
         clr_mask = {lf[11:0], lf[31:12]};
         halted = lf[5];
         cyc();
      end
      clr_valid = 0;

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule